// File: doc/BRIEF.md
# Local Interrupt Vector Table Controller

This block sits beside one processor core and decides which local interrupt, if any, is offered to it. Four sources feed it: a timer event pulse, an error event pulse and two asynchronous local interrupt pins. Each source has its own table entry holding a vector, a delivery mode, a trigger bit and a mask. A small register set, reached through a 32-bit read/write port addressed by byte offset, holds these entries. It also holds a task priority threshold, a spurious-vector register that carries the global software enable, and a destination-format register.

The effective trigger style of a source is not always the programmed bit. Only a Fixed-mode entry on a pin honours the trigger bit. An external-controller entry on a pin is always level-sensitive. Every other mode, and the timer and error entries in any mode, are edge-sensitive. One request at a time is offered on `irq_req` with its vector and delivery mode. The core acknowledges an edge request with `irq_ack`. A level request stays raised until an end-of-interrupt write has been seen and the pin has gone low.

Top module: `lvt_ctrl`

## Requirements
- R1: After reset, all four table entries read 0x00010000 (masked, vector 0), the spurious register reads 0x000000FF (software enable 0), task priority reads 0, destination format reads 0xFFFFFFFF, and `irq_req` is low.
- R2: Register offsets are: task priority 0x080, end-of-interrupt 0x0B0 (write only, reads 0), destination format 0x0E0, spurious 0x0F0, timer 0x320, pin 0 0x350, pin 1 0x360, error 0x370. An entry keeps bits 16 (mask), 15 (trigger, 1 = level), 10:8 (mode) and 7:0 (vector). The spurious register keeps bits 12, 9, 8 (enable) and 7:0. Task priority keeps bits 7:0. Destination format keeps bits 31:28, and its bits 27:0 read as ones. Other bits read 0. Read data appears in the cycle after the read strobe.
- R3: While spurious bit 8 is 0, no request is raised, and anything pending is discarded.
- R4: A source whose entry has bit 16 set raises no request. An event that arrives while the source is masked is lost and is not delivered after unmasking.
- R5: A Fixed-mode (000) pin entry with trigger 0 raises one request per rising edge of the pin. `irq_ack` clears that request, and a pin held high does not raise it again.
- R6: A Fixed-mode pin entry with trigger 1 is level-sensitive. Its request stays high through `irq_ack` and falls only after a write to 0x0B0 and a low pin, in either order.
- R7: Mode 111 (external controller) on a pin is level-sensitive even when its trigger bit is 0.
- R8: Modes 100, 010 and 101 on a pin, and the timer and error entries in any mode, are edge-sensitive even when the trigger bit is 1.
- R9: A Fixed-mode request is offered only while vector bits 7:4 are strictly greater than task priority bits 7:4. Until then it is held pending. Non-Fixed modes ignore the priority.
- R10: When several sources are deliverable, the one offered is chosen in the order timer, pin 0, pin 1, error.
- R11: While `irq_req` is high, `irq_vec` and `irq_mode` carry the vector and mode of the offered entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| lint_pin | input | 2 | Asynchronous local interrupt pins 0 and 1 |
| timer_evt | input | 1 | One-cycle timer event |
| err_evt | input | 1 | One-cycle error event |
| irq_ack | input | 1 | Core accepts the offered request |
| irq_req | output | 1 | Request offered to the core |
| irq_vec | output | 8 | Vector of the offered request |
| irq_mode | output | 3 | Delivery mode of the offered request |

## Verification
The hardest states to reach are a request held back by the task priority and a pending request dropped by disabling the block. In both, the pending bit is hidden and only its later effect shows at the ports. The stimulus raises the priority threshold before it pulses the timer, confirms that no request appears, and then lowers the threshold to release the request. For the dropped case it toggles the software enable off and on while the request is held back, lowers the threshold, and confirms that nothing is delivered. Level hold is exercised with end-of-interrupt arriving both before and after the pin falls.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NSRC   = 4;

  localparam logic [ADDR_W-1:0] OFS_TPR = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_EOI = 12'h0B0;
  localparam logic [ADDR_W-1:0] OFS_DFR = 12'h0E0;
  localparam logic [ADDR_W-1:0] OFS_SVR = 12'h0F0;
  localparam logic [ADDR_W-1:0] OFS_TMR = 12'h320;
  localparam logic [ADDR_W-1:0] OFS_PN0 = 12'h350;
  localparam logic [ADDR_W-1:0] OFS_PN1 = 12'h360;
  localparam logic [ADDR_W-1:0] OFS_ERR = 12'h370;

  localparam logic [2:0] DM_FIXED = 3'b000;
  localparam logic [2:0] DM_EXT   = 3'b111;

  // Source order is also the delivery priority (lowest index first).
  localparam logic [NSRC-1:0] PIN_SRCS = 4'b0110;

  typedef struct packed {
    logic       mask;
    logic       trig;
    logic [2:0] mode;
    logic [7:0] vec;
  } lvt_entry_t;

  localparam lvt_entry_t ENTRY_RST = '{mask: 1'b1, trig: 1'b0, mode: 3'b000, vec: 8'h00};

  function automatic logic [ADDR_W-1:0] src_ofs(input int s);
    case (s)
      0:       return OFS_TMR;
      1:       return OFS_PN0;
      2:       return OFS_PN1;
      default: return OFS_ERR;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] entry_word(input lvt_entry_t e);
    return {15'b0, e.mask, e.trig, 4'b0, e.mode, e.vec};
  endfunction
endpackage

// File: rtl/lvt_regs.sv
module lvt_regs
  import lvt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output lvt_entry_t [NSRC-1:0]   ent,
  output logic [7:0]              tpr,
  output logic                    sw_en,
  output logic                    eoi
);
  lvt_entry_t        ent_q [NSRC];
  logic [7:0]        tpr_q;
  logic [7:0]        svr_vec_q;
  logic              svr_en_q, svr_fpc_q, svr_eoib_q;
  logic [3:0]        dfr_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              unused_bits;

  assign unused_bits = ^{wdata[27:17], wdata[14:13], wdata[11]};

  for (genvar s = 0; s < NSRC; s++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q[s] <= ENTRY_RST;
      end else if (wr_en && addr == src_ofs(s)) begin
        ent_q[s] <= '{mask: wdata[16], trig: wdata[15], mode: wdata[10:8], vec: wdata[7:0]};
      end
    end
    assign ent[s] = ent_q[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tpr_q      <= 8'h00;
      svr_vec_q  <= 8'hFF;
      svr_en_q   <= 1'b0;
      svr_fpc_q  <= 1'b0;
      svr_eoib_q <= 1'b0;
      dfr_q      <= 4'hF;
    end else if (wr_en) begin
      if (addr == OFS_TPR) tpr_q <= wdata[7:0];
      if (addr == OFS_DFR) dfr_q <= wdata[31:28];
      if (addr == OFS_SVR) begin
        svr_vec_q  <= wdata[7:0];
        svr_en_q   <= wdata[8];
        svr_fpc_q  <= wdata[9];
        svr_eoib_q <= wdata[12];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == OFS_TPR) rd_mux = {24'b0, tpr_q};
    if (addr == OFS_DFR) rd_mux = {dfr_q, 28'hFFFFFFF};
    if (addr == OFS_SVR) rd_mux = {19'b0, svr_eoib_q, 2'b0, svr_fpc_q, svr_en_q, svr_vec_q};
    for (int s = 0; s < NSRC; s++) begin
      if (addr == src_ofs(s)) rd_mux = entry_word(ent_q[s]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
  assign tpr   = tpr_q;
  assign sw_en = svr_en_q;
  assign eoi   = wr_en && addr == OFS_EOI;
endmodule

// File: rtl/lvt_pin_sync.sv
module lvt_pin_sync #(
  parameter int NPIN   = 2,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] lvl,
  output logic [NPIN-1:0] rise
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [STAGES:0] sh_q;
    always_ff @(posedge clk) begin
      if (rst) sh_q <= '0;
      else     sh_q <= {sh_q[STAGES-1:0], pin_i[p]};
    end
    assign lvl[p]  = sh_q[STAGES-1];
    assign rise[p] = sh_q[STAGES-1] & ~sh_q[STAGES];
  end
endmodule

// File: rtl/lvt_pend.sv
module lvt_pend
  import lvt_pkg::*;
#(
  parameter int NS = NSRC,
  localparam int SW = $clog2(NS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  lvt_entry_t [NS-1:0]  ent,
  input  logic                 sw_en,
  input  logic [3:0]           tpr_class,
  input  logic                 eoi,
  input  logic [NS-1:0]        src_lvl,
  input  logic [NS-1:0]        src_evt,
  input  logic                 ack,
  output logic                 req,
  output logic [7:0]           vec,
  output logic [2:0]           mode,
  output logic [SW-1:0]        src
);
  logic [NS-1:0] pend_q, eoi_seen_q, level_s, elig, ack_hit, gate;
  logic          req_q;
  logic [7:0]    vec_q;
  logic [2:0]    mode_q;
  logic [SW-1:0] src_q, sel;

  for (genvar s = 0; s < NS; s++) begin : g_src
    assign level_s[s] = PIN_SRCS[s] &
                        ((ent[s].mode == DM_EXT) | ((ent[s].mode == DM_FIXED) & ent[s].trig));
    assign elig[s]    = sw_en & ~ent[s].mask;
    assign ack_hit[s] = ack & req_q & (src_q == SW'(s)) & ~level_s[s];
    assign gate[s]    = pend_q[s] & elig[s] & ~ack_hit[s] &
                        ((ent[s].mode != DM_FIXED) | (ent[s].vec[7:4] > tpr_class));

    always_ff @(posedge clk) begin
      if (rst || !elig[s]) begin
        pend_q[s]     <= 1'b0;
        eoi_seen_q[s] <= 1'b0;
      end else if (level_s[s]) begin
        if (pend_q[s]) begin
          if ((eoi_seen_q[s] || eoi) && !src_lvl[s]) begin
            pend_q[s]     <= 1'b0;
            eoi_seen_q[s] <= 1'b0;
          end else if (eoi) begin
            eoi_seen_q[s] <= 1'b1;
          end
        end else if (src_lvl[s]) begin
          pend_q[s] <= 1'b1;
        end
      end else begin
        eoi_seen_q[s] <= 1'b0;
        if (src_evt[s])      pend_q[s] <= 1'b1;
        else if (ack_hit[s]) pend_q[s] <= 1'b0;
      end
    end
  end

  always_comb begin
    sel = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (gate[i]) sel = SW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      vec_q  <= 8'h00;
      mode_q <= 3'b000;
      src_q  <= '0;
    end else begin
      req_q  <= |gate;
      vec_q  <= ent[sel].vec;
      mode_q <= ent[sel].mode;
      src_q  <= sel;
    end
  end

  assign req  = req_q;
  assign vec  = vec_q;
  assign mode = mode_q;
  assign src  = src_q;
endmodule

// File: rtl/lvt_ctrl.sv
module lvt_ctrl
  import lvt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [1:0]        lint_pin,
  input  logic              timer_evt,
  input  logic              err_evt,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [7:0]        irq_vec,
  output logic [2:0]        irq_mode
);
  localparam int SW = $clog2(NSRC);

  lvt_entry_t [NSRC-1:0] ent_w;
  logic [7:0]            tpr_w;
  logic                  sw_en, eoi_w;
  logic [1:0]            pin_lvl, pin_rise;
  logic [NSRC-1:0]       src_lvl, src_evt, mask_w;
  logic [SW-1:0]         src_w;

  lvt_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ent(ent_w), .tpr(tpr_w),
    .sw_en(sw_en), .eoi(eoi_w)
  );

  lvt_pin_sync #(.NPIN(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(lint_pin), .lvl(pin_lvl), .rise(pin_rise)
  );

  assign src_evt = {err_evt, pin_rise[1], pin_rise[0], timer_evt};
  assign src_lvl = {1'b0, pin_lvl[1], pin_lvl[0], 1'b0};

  for (genvar s = 0; s < NSRC; s++) begin : g_mask
    assign mask_w[s] = ent_w[s].mask;
  end

  lvt_pend #(.NS(NSRC)) u_pend (
    .clk(clk), .rst(rst), .ent(ent_w), .sw_en(sw_en), .tpr_class(tpr_w[7:4]),
    .eoi(eoi_w), .src_lvl(src_lvl), .src_evt(src_evt), .ack(irq_ack),
    .req(irq_req), .vec(irq_vec), .mode(irq_mode), .src(src_w)
  );
endmodule

// File: rtl/lvt_ctrl_chk.sv
module lvt_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_rd,
  input logic [11:0] reg_addr,
  input logic [31:0] reg_rdata,
  input logic        irq_req,
  input logic [7:0]  irq_vec,
  input logic [2:0]  irq_mode,
  input logic        sw_en,
  input logic [7:0]  tpr,
  input logic [3:0]  mask_bits,
  input logic [1:0]  irq_src
);
  assert_tpr_read_narrow_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_rd) && $past(reg_addr) == 12'h080) |-> reg_rdata[31:8] == 24'h0);

  assert_silent_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(sw_en));

  assert_masked_never_offered_R4: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (($past(mask_bits) >> irq_src) & 4'b0001) == 4'b0000);

  assert_fixed_above_priority_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_mode == 3'b000) |-> irq_vec[7:4] > $past(tpr[7:4]));
endmodule

bind lvt_ctrl lvt_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .irq_req(irq_req), .irq_vec(irq_vec), .irq_mode(irq_mode), .sw_en(sw_en),
  .tpr(tpr_w), .mask_bits(mask_w), .irq_src(src_w)
);

// File: tb/lvt_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvt_ctrl_tb_top;
  localparam logic [11:0] A_TPR = 12'h080, A_EOI = 12'h0B0, A_DFR = 12'h0E0, A_SVR = 12'h0F0;
  localparam logic [11:0] A_TMR = 12'h320, A_PN0 = 12'h350, A_PN1 = 12'h360, A_ERR = 12'h370;
  localparam logic [31:0] MASKED = 32'h0001_0000;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0]  lint_pin = 2'b00;
  logic        timer_evt = 1'b0, err_evt = 1'b0, irq_ack = 1'b0;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic [2:0]  irq_mode;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  lvt_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lint_pin(lint_pin),
    .timer_evt(timer_evt), .err_evt(err_evt), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_mode(irq_mode)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_req(input int n, output logic seen);
    seen = 1'b0;
    for (int i = 0; i < n && !seen; i++) begin
      @(negedge clk);
      if (irq_req) seen = 1'b1;
    end
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk); timer_evt = 1'b1;
    @(negedge clk); timer_evt = 1'b0;
  endtask

  task automatic mask_all();
    wr(A_TMR, MASKED); wr(A_PN0, MASKED); wr(A_PN1, MASKED); wr(A_ERR, MASKED);
    idle(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_req after reset", {31'b0, irq_req}, 32'h0);
    rd(A_TMR, d); chk("R1 timer entry", d, MASKED);
    rd(A_PN0, d); chk("R1 pin0 entry", d, MASKED);
    rd(A_PN1, d); chk("R1 pin1 entry", d, MASKED);
    rd(A_ERR, d); chk("R1 error entry", d, MASKED);
    rd(A_SVR, d); chk("R1 spurious", d, 32'h0000_00FF);
    rd(A_TPR, d); chk("R1 priority", d, 32'h0);
    rd(A_DFR, d); chk("R1 dest format", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_PN1, 32'hFFFF_FFFF); rd(A_PN1, d); chk("R2 entry field mask", d, 32'h0001_87FF);
    wr(A_SVR, 32'hFFFF_FFFF); rd(A_SVR, d); chk("R2 spurious fields", d, 32'h0000_13FF);
    wr(A_TPR, 32'hFFFF_FFAB); rd(A_TPR, d); chk("R2 priority", d, 32'h0000_00AB);
    wr(A_DFR, 32'h0000_0000); rd(A_DFR, d); chk("R2 dest format", d, 32'h0FFF_FFFF);
    rd(A_EOI, d); chk("R2 eoi reads zero", d, 32'h0);
    wr(A_TPR, 32'h0); wr(A_PN1, MASKED); wr(A_SVR, 32'h0000_01FF);
  endtask

  task automatic t_edge();
    logic seen;
    mask_all();
    wr(A_PN0, 32'h0000_0021);
    @(negedge clk); lint_pin[0] = 1'b1;
    wait_req(8, seen); chk("R5 edge request raised", {31'b0, seen}, 32'h1);
    chk("R11 vector", {24'b0, irq_vec}, 32'h21);
    chk("R11 mode", {29'b0, irq_mode}, 32'h0);
    ack(); chk("R5 cleared by ack", {31'b0, irq_req}, 32'h0);
    idle(4); chk("R5 held pin no repeat", {31'b0, irq_req}, 32'h0);
    lint_pin[0] = 1'b0; idle(4); lint_pin[0] = 1'b1;
    wait_req(8, seen); chk("R5 second edge", {31'b0, seen}, 32'h1);
    ack(); lint_pin[0] = 1'b0; idle(4);
    chk("R5 idle after second ack", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_level();
    logic seen;
    mask_all();
    wr(A_PN1, 32'h0000_8055);
    @(negedge clk); lint_pin[1] = 1'b1;
    wait_req(8, seen); chk("R6 level raised", {31'b0, seen}, 32'h1);
    chk("R11 level vector", {24'b0, irq_vec}, 32'h55);
    ack(); idle(3); chk("R6 held after ack", {31'b0, irq_req}, 32'h1);
    lint_pin[1] = 1'b0; idle(6); chk("R6 pin low no eoi held", {31'b0, irq_req}, 32'h1);
    wr(A_EOI, 32'h0); idle(3); chk("R6 dropped after eoi", {31'b0, irq_req}, 32'h0);
    lint_pin[1] = 1'b1;
    wait_req(8, seen); chk("R6 raised again", {31'b0, seen}, 32'h1);
    wr(A_EOI, 32'h0); idle(4); chk("R6 eoi with pin high held", {31'b0, irq_req}, 32'h1);
    lint_pin[1] = 1'b0; idle(6); chk("R6 dropped after pin low", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_extint();
    logic seen;
    mask_all();
    wr(A_PN0, 32'h0000_0730);
    @(negedge clk); lint_pin[0] = 1'b1;
    wait_req(8, seen); chk("R7 ext raised", {31'b0, seen}, 32'h1);
    chk("R11 ext mode", {29'b0, irq_mode}, 32'h7);
    ack(); idle(3); chk("R7 ext level held", {31'b0, irq_req}, 32'h1);
    lint_pin[0] = 1'b0; wr(A_EOI, 32'h0); idle(6);
    chk("R7 ext released", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_edge_forced();
    logic seen;
    mask_all();
    wr(A_PN1, 32'h0000_8462);
    @(negedge clk); lint_pin[1] = 1'b1;
    wait_req(8, seen); chk("R8 nmi raised", {31'b0, seen}, 32'h1);
    chk("R11 nmi mode", {29'b0, irq_mode}, 32'h4);
    ack(); idle(4); chk("R8 nmi edge despite trig", {31'b0, irq_req}, 32'h0);
    lint_pin[1] = 1'b0;
    mask_all();
    wr(A_TMR, 32'h0000_8070);
    pulse_tmr();
    wait_req(4, seen); chk("R8 timer raised", {31'b0, seen}, 32'h1);
    ack(); idle(4); chk("R8 timer edge despite trig", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_tpr();
    logic seen;
    mask_all();
    wr(A_TPR, 32'h50); wr(A_TMR, 32'h0000_0045);
    pulse_tmr(); wait_req(8, seen); chk("R9 blocked below priority", {31'b0, seen}, 32'h0);
    wr(A_TPR, 32'h40); wait_req(6, seen); chk("R9 blocked at equal class", {31'b0, seen}, 32'h0);
    wr(A_TPR, 32'h3F); wait_req(4, seen); chk("R9 released after drop", {31'b0, seen}, 32'h1);
    chk("R9 released vector", {24'b0, irq_vec}, 32'h45);
    ack(); mask_all();
    wr(A_TPR, 32'hF0); wr(A_PN1, 32'h0000_0412);
    @(negedge clk); lint_pin[1] = 1'b1;
    wait_req(8, seen); chk("R9 nmi ignores priority", {31'b0, seen}, 32'h1);
    ack(); lint_pin[1] = 1'b0; wr(A_TPR, 32'h0); idle(4);
  endtask

  task automatic t_prio();
    logic seen;
    mask_all();
    wr(A_TMR, 32'h0000_0040); wr(A_ERR, 32'h0000_0041);
    @(negedge clk); timer_evt = 1'b1; err_evt = 1'b1;
    @(negedge clk); timer_evt = 1'b0; err_evt = 1'b0;
    wait_req(4, seen); chk("R10 request raised", {31'b0, seen}, 32'h1);
    chk("R10 timer first", {24'b0, irq_vec}, 32'h40);
    ack(); chk("R10 error next req", {31'b0, irq_req}, 32'h1);
    chk("R10 error next vec", {24'b0, irq_vec}, 32'h41);
    ack(); idle(2); chk("R10 all served", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_mask();
    logic seen;
    mask_all();
    wr(A_ERR, 32'h0001_0041);
    @(negedge clk); err_evt = 1'b1; @(negedge clk); err_evt = 1'b0;
    wait_req(8, seen); chk("R4 masked silent", {31'b0, seen}, 32'h0);
    wr(A_ERR, 32'h0000_0041);
    wait_req(8, seen); chk("R4 masked event lost", {31'b0, seen}, 32'h0);
  endtask

  task automatic t_swen();
    logic seen;
    mask_all();
    wr(A_TMR, 32'h0000_0040); wr(A_SVR, 32'h0000_00FF);
    pulse_tmr(); wait_req(8, seen); chk("R3 disabled silent", {31'b0, seen}, 32'h0);
    wr(A_SVR, 32'h0000_01FF); wr(A_TPR, 32'hF0);
    pulse_tmr(); idle(2);
    wr(A_SVR, 32'h0000_00FF); wr(A_SVR, 32'h0000_01FF); wr(A_TPR, 32'h0);
    wait_req(8, seen); chk("R3 pending discarded", {31'b0, seen}, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_edge();
    t_level();
    t_extint();
    t_edge_forced();
    t_tpr();
    t_prio();
    t_mask();
    t_swen();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule